// File: doc/BRIEF.md
# Host Port Receive Path

This block is the receive half of an 8-bit parallel host port. The DSP core hands it 16-bit words over a valid/ready handshake. Each accepted word is split into a high receive byte and a low receive byte, which an external host reads over a small address-decoded bus. A full flag records that a word is waiting. The full flag also throttles the core side, so a word that the host has not yet read is never overwritten.

The host reaches a control register, a status register and an 8-bit interrupt vector register over the same bus. The control register holds a request enable, a byte-order select, a DMA enable and a self-clearing initialize bit. The block drives an active-low request pin when requests are enabled and a word is waiting. In a vectored acknowledge cycle (request and acknowledge both low, DMA off) the block drives the vector register onto the data bus. The data bus is split into input, output and output-enable signals for a pad ring outside the block.

Top module: `host_rx_port`

## Requirements
- R1: In the clock edge where core_valid_i and core_ready_o are both high, bits 15:8 of core_data_i are loaded into the high receive byte (address 6) and bits 7:0 into the low receive byte (address 7). The full flag sets at that same edge.
- R2: core_ready_o is high exactly when the full flag is clear. While the flag is set, an offered word leaves both receive bytes unchanged.
- R3: The full flag clears at the clock edge on which the host read strobe is seen to fall after a read of the last byte. The last byte is address 7 when control bit 1 (byte order) is 0, and address 6 when that bit is 1. Reading the other receive byte leaves the flag set.
- R4: A host write to address 0 with data bit 3 set clears the full flag. Bit 3 is not stored and always reads back as 0.
- R5: host_req_no is low exactly when control bit 0 (request enable) is 1 and the full flag is set.
- R6: A read of address 2 returns the full flag in bit 0 and zeros in bits 7:1, whatever the request enable setting.
- R7: The vector register at address 3 resets to 8'h0F. A host write to it is read back unchanged.
- R8: When host_req_no and host_ack_ni are both low and control bit 2 (DMA enable) is 0, the block drives the vector register on host_data_o with host_data_oe_o high. When DMA is enabled, or when the request pin is high, the acknowledge input drives nothing.
- R9: host_data_oe_o is low unless a read strobe or an acknowledge cycle is active. Reads of addresses 1, 4 and 5 return 0.
- R10: Control bits 2:0 reset to 0 and read back at address 0 as written. Bits 7:3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_data_i | input | 16 | Word from the core transmit holding register |
| core_valid_i | input | 1 | Core word valid |
| core_ready_o | output | 1 | Block can accept a word |
| host_addr_i | input | 3 | Host register address |
| host_rd_i | input | 1 | Host read strobe, active high |
| host_wr_i | input | 1 | Host write strobe, active high |
| host_data_i | input | 8 | Host write data from pad |
| host_data_o | output | 8 | Read or vector data to pad |
| host_data_oe_o | output | 1 | Pad output enable |
| host_ack_ni | input | 1 | Host acknowledge, active low |
| host_req_no | output | 1 | Host request, active low |

## Verification
The read data path and the output enable are combinational. They are sampled 1 ns after the strobe or acknowledge is applied, in the same cycle. A core load and a host write take effect at the first rising edge that sees them. A full-flag clear from a read takes effect at the second edge: the first edge registers the strobe, and the second sees it fall. The bench therefore changes inputs 5 ns after an edge and reads status only after the edge count that each effect needs. It does this with fixed step tasks, so no check straddles an edge.

// File: rtl/host_rx_pkg.sv
package host_rx_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] A_VEC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_HI   = 3'd6;
  localparam logic [ADDR_W-1:0] A_LO   = 3'd7;

  // control bit positions
  localparam int C_RREQ  = 0;
  localparam int C_ORDER = 1;
  localparam int C_DMA   = 2;
  localparam int C_INIT  = 3;

  typedef struct packed {
    logic dma_en;
    logic hi_last;
    logic req_en;
  } ctrl_t;
endpackage

// File: rtl/host_rx_regs.sv
module host_rx_regs
  import host_rx_pkg::*;
#(
  parameter int          BYTE_W  = 8,
  parameter logic [BYTE_W-1:0] VEC_RST = 8'h0F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output ctrl_t             ctrl_o,
  output logic [BYTE_W-1:0] vec_o,
  output logic              init_o
);
  logic wr_q, wr_evt;

  assign wr_evt = wr_i && !wr_q;
  assign init_o = wr_evt && (addr_i == A_CTRL) && wdata_i[C_INIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b0;
      ctrl_o <= '0;
      vec_o  <= VEC_RST;
    end else begin
      wr_q <= wr_i;
      if (wr_evt && addr_i == A_CTRL) begin
        ctrl_o.req_en  <= wdata_i[C_RREQ];
        ctrl_o.hi_last <= wdata_i[C_ORDER];
        ctrl_o.dma_en  <= wdata_i[C_DMA];
      end
      if (wr_evt && addr_i == A_VEC) vec_o <= wdata_i;
    end
  end

  assert_vec_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_q && addr_i == A_VEC) |=> vec_o == $past(wdata_i));
endmodule

// File: rtl/host_rx_buf.sv
module host_rx_buf
  import host_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hi_last_i,
  input  logic              init_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o,
  output logic              full_o
);
  logic              rd_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              last_done;
  logic              load;
  logic [ADDR_W-1:0] last_addr;

  assign last_addr = hi_last_i ? A_HI : A_LO;
  assign last_done = rd_q && !rd_i && (rd_addr_q == last_addr);
  assign ready_o   = !full_o;
  assign load      = valid_i && ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      rd_q <= rd_i;
      if (rd_i) rd_addr_q <= addr_i;
    end
  end

  // load wins over a clear: a handshaken word must not be lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      hi_o   <= '0;
      lo_o   <= '0;
    end else if (load) begin
      full_o <= 1'b1;
      hi_o   <= word_i[WORD_W-1:BYTE_W];
      lo_o   <= word_i[BYTE_W-1:0];
    end else if (last_done || init_i) begin
      full_o <= 1'b0;
    end
  end

  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (full_o && hi_o == $past(word_i[WORD_W-1:BYTE_W])
                              && lo_o == $past(word_i[BYTE_W-1:0])));
  assert_hold_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> ($stable(hi_o) && $stable(lo_o)));
  assert_clear_on_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_done && full_o) |=> !full_o);
  assert_clear_on_init_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_i && full_o) |=> !full_o);
endmodule

// File: rtl/host_rx_bus.sv
module host_rx_bus
  import host_rx_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ack_cycle_i,
  input  ctrl_t             ctrl_i,
  input  logic              full_i,
  input  logic [BYTE_W-1:0] vec_i,
  input  logic [BYTE_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] lo_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              oe_o
);
  logic [BYTE_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      A_CTRL:  rd_mux = BYTE_W'({ctrl_i.dma_en, ctrl_i.hi_last, ctrl_i.req_en});
      A_STAT:  rd_mux = BYTE_W'(full_i);
      A_VEC:   rd_mux = vec_i;
      A_HI:    rd_mux = hi_i;
      A_LO:    rd_mux = lo_i;
      default: rd_mux = '0;
    endcase
  end

  // acknowledge cycle has priority over a read strobe
  always_comb begin
    oe_o   = ack_cycle_i || rd_i;
    data_o = '0;
    if (ack_cycle_i)  data_o = vec_i;
    else if (rd_i)    data_o = rd_mux;
  end
endmodule

// File: rtl/host_rx_port.sv
module host_rx_port
  import host_rx_pkg::*;
#(
  parameter int          WORD_W  = 16,
  parameter logic [7:0]  VEC_RST = 8'h0F,
  localparam int         BYTE_W  = WORD_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] core_data_i,
  input  logic              core_valid_i,
  output logic              core_ready_o,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [BYTE_W-1:0] host_data_i,
  output logic [BYTE_W-1:0] host_data_o,
  output logic              host_data_oe_o,
  input  logic              host_ack_ni,
  output logic              host_req_no
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] vec, rx_hi, rx_lo;
  logic              init, full, ack_cycle;

  host_rx_regs #(.BYTE_W(BYTE_W), .VEC_RST(BYTE_W'(VEC_RST))) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (host_wr_i),
    .addr_i  (host_addr_i),
    .wdata_i (host_data_i),
    .ctrl_o  (ctrl),
    .vec_o   (vec),
    .init_o  (init)
  );

  host_rx_buf #(.WORD_W(WORD_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_i    (core_data_i),
    .valid_i   (core_valid_i),
    .ready_o   (core_ready_o),
    .rd_i      (host_rd_i),
    .addr_i    (host_addr_i),
    .hi_last_i (ctrl.hi_last),
    .init_i    (init),
    .hi_o      (rx_hi),
    .lo_o      (rx_lo),
    .full_o    (full)
  );

  assign host_req_no = !(ctrl.req_en && full);
  assign ack_cycle   = !host_req_no && !host_ack_ni && !ctrl.dma_en;

  host_rx_bus #(.BYTE_W(BYTE_W)) u_bus (
    .rd_i        (host_rd_i),
    .addr_i      (host_addr_i),
    .ack_cycle_i (ack_cycle),
    .ctrl_i      (ctrl),
    .full_i      (full),
    .vec_i       (vec),
    .hi_i        (rx_hi),
    .lo_i        (rx_lo),
    .data_o      (host_data_o),
    .oe_o        (host_data_oe_o)
  );

  assert_ready_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_ready_o == !full);
  assert_req_pin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_ready_o && ctrl.req_en) |-> !host_req_no);
  assert_vec_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_req_no && !host_ack_ni && !ctrl.dma_en) |-> (host_data_oe_o && host_data_o == vec));
  assert_bus_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_rd_i && (host_ack_ni || host_req_no)) |-> !host_data_oe_o);
endmodule

// File: tb/tb_host_rx_port.sv
module tb_host_rx_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] core_data = '0;
  logic        core_valid = 1'b0;
  logic        core_ready;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        oe;
  logic        ack_n = 1'b1;
  logic        req_n;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  host_rx_port dut (
    .clk_i(clk), .rst_ni(rst_n), .core_data_i(core_data), .core_valid_i(core_valid),
    .core_ready_o(core_ready), .host_addr_i(addr), .host_rd_i(rd), .host_wr_i(wr),
    .host_data_i(din), .host_data_o(dout), .host_data_oe_o(oe),
    .host_ack_ni(ack_n), .host_req_no(req_n)
  );

  // op: 0 load, 1 write, 2 read
  function automatic logic [32:0] v(int op, int a, int d, int e, int r);
    return {op[1:0], a[2:0], d[15:0], e[7:0], r[3:0]};
  endfunction

  localparam int NV = 19;
  localparam logic [32:0] TBL [NV] = '{
    v(2, 3, 0,      8'h0F, 7),   // R7 reset vector
    v(2, 0, 0,      8'h00, 10),  // R10 control reset
    v(2, 2, 0,      8'h00, 6),   // R6 empty status
    v(0, 0, 16'hA55A, 0,   1),
    v(2, 2, 0,      8'h01, 1),   // R1 flag set
    v(2, 6, 0,      8'hA5, 1),   // R1 high byte
    v(2, 2, 0,      8'h01, 3),   // R3 high read keeps flag (order 0)
    v(2, 7, 0,      8'h5A, 1),   // R1 low byte
    v(2, 2, 0,      8'h00, 3),   // R3 cleared by last byte
    v(1, 3, 8'h42,  0,     7),
    v(2, 3, 0,      8'h42, 7),   // R7 readback
    v(1, 0, 8'h03,  0,     10),
    v(2, 0, 0,      8'h03, 10),  // R10 readback
    v(0, 0, 16'h1234, 0,   1),
    v(2, 7, 0,      8'h34, 1),
    v(2, 2, 0,      8'h01, 3),   // R3 order 1: low read keeps flag
    v(2, 6, 0,      8'h12, 1),
    v(2, 2, 0,      8'h00, 3),   // R3 order 1: high read clears
    v(2, 5, 0,      8'h00, 9)    // R9 unmapped
  };

  task automatic step();
    @(posedge clk); #5;
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [2:0] a, logic [7:0] d);
    addr = a; din = d; wr = 1'b1; step(); wr = 1'b0; step();
  endtask

  task automatic host_rd(logic [2:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1; #1; d = dout; step(); rd = 1'b0; step();
  endtask

  task automatic core_load(logic [15:0] w);
    core_data = w; core_valid = 1'b1; step(); core_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] rv;
    step(); step();
    rst_n = 1'b1;
    step();
    check("R5 reset req", 16'(req_n), 16'd1);
    check("R2 reset ready", 16'(core_ready), 16'd1);
    check("R9 reset oe", 16'(oe), 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] e;
      e = TBL[i];
      case (e[32:31])
        2'd0: core_load(e[27:12]);
        2'd1: host_wr(e[30:28], e[19:12]);
        default: begin
          host_rd(e[30:28], rv);
          check($sformatf("R%0d table %0d", e[3:0], i), 16'(rv), 16'(e[11:4]));
        end
      endcase
    end

    // control = req_en | hi_last, flag clear
    check("R5 idle req", 16'(req_n), 16'd1);
    core_load(16'hBEEF);
    check("R5 req asserted", 16'(req_n), 16'd0);
    check("R2 ready low", 16'(core_ready), 16'd0);
    core_load(16'h1111);
    host_rd(3'd7, rv);
    check("R2 no overwrite", 16'(rv), 16'h00EF);
    host_rd(3'd2, rv);
    check("R2 still full", 16'(rv), 16'h0001);

    ack_n = 1'b0; #1;
    check("R8 ack oe", 16'(oe), 16'd1);
    check("R8 ack data", 16'(dout), 16'h0042);
    ack_n = 1'b1; step();

    host_wr(3'd0, 8'h07);
    ack_n = 1'b0; #1;
    check("R8 dma blocks ack", 16'(oe), 16'd0);
    ack_n = 1'b1; step();

    host_wr(3'd0, 8'h00);
    check("R5 disabled req", 16'(req_n), 16'd1);
    host_rd(3'd2, rv);
    check("R6 status with req off", 16'(rv), 16'h0001);
    ack_n = 1'b0; #1;
    check("R8 ack without req", 16'(oe), 16'd0);
    ack_n = 1'b1; step();

    host_wr(3'd0, 8'h08);
    host_rd(3'd2, rv);
    check("R4 init clears", 16'(rv), 16'h0000);
    check("R4 ready after init", 16'(core_ready), 16'd1);
    host_rd(3'd0, rv);
    check("R4 init reads 0", 16'(rv), 16'h0000);

    host_wr(3'd0, 8'hFD);
    host_rd(3'd0, rv);
    check("R10 upper bits 0", 16'(rv), 16'h0005);
    host_rd(3'd4, rv);
    check("R9 addr 4", 16'(rv), 16'h0000);
    check("R9 oe idle", 16'(oe), 16'd0);

    finish_run();
  end
endmodule